// File: doc/BRIEF.md
# RV32 Multiply Execution Unit

This unit executes the four multiply operations of the RV32 M group. It takes one 32-bit instruction word and the values of its two source registers. It decodes the operation and forms the full 64-bit product, applying the signedness each operation requires to each operand. It then returns the low or the high result word together with the destination register index. Words that are not in the multiply group are marked illegal and are not executed.

Transfers on both sides use a valid/ready handshake. The unit holds one operation at a time. An accepted operation gives its result a fixed number of cycles later, set by the parameter `LAT`. The result then stays at the output until the consumer takes it. No new instruction is accepted before that.

Top module: `mulh_unit`

## Requirements
- R1: An instruction is in the multiply group when bits 6:0 are 0110011 and bits 31:25 are 0000001. Bits 14:12 equal to 000 select MUL, which returns the low 32 bits of the product rs1 × rs2 (bits 19:15 and 24:20 name the sources).
- R2: Bits 14:12 equal to 001 select MULH, which returns bits 63:32 of the product with both operands taken as signed.
- R3: Bits 14:12 equal to 011 select MULHU, which returns bits 63:32 of the product with both operands taken as unsigned.
- R4: Bits 14:12 equal to 010 select MULHSU, which returns bits 63:32 of the product with the rs1 value signed and the rs2 value unsigned. The roles are never swapped.
- R5: `out_rd_o` carries bits 11:7 of the accepted instruction, for legal and illegal words alike.
- R6: A word with bits 14:12 from 100 to 111, or with any other opcode or bits 31:25, yields `out_illegal_o` = 1 and `out_data_o` = 0. A legal operation yields `out_illegal_o` = 0.
- R7: When an instruction is accepted on clock edge k, `out_valid_o` first goes high after edge k+LAT-1.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o`, `out_rd_o` and `out_illegal_o` hold their values.
- R9: `in_ready_o` is low from the acceptance edge until the result is taken. On the edge where `out_valid_o` and `out_ready_i` are both high, the result is taken: `out_valid_o` falls and `in_ready_o` rises.
- R10: After reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction and operands are valid |
| in_ready_o | output | 1 | Unit can accept an instruction |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of the first source register |
| rs2_val_i | input | 32 | Value of the second source register |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_data_o | output | 32 | Result word |
| out_rd_o | output | 5 | Destination register index |
| out_illegal_o | output | 1 | Instruction was not a multiply |

## Verification
A wrong signedness flag in the decoded control word leaves the low word untouched. It appears only in the high word of MULH, MULHU or MULHSU, and only when an operand has its top bit set. The directed cases 0x80000000 × 0xFFFFFFFF and a negative rs1 against rs2 = 0xFFFFFFFF expose it on the first result, LAT cycles after acceptance. A stuck or misrouted stage-valid bit shows at once as a wrong result latency, as a result that never arrives, or as `in_ready_o` coming back before the result is taken.

// File: rtl/mulh_pkg.sv
package mulh_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned REG_IDX_W = 5;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;
  localparam logic [6:0] F7_MULDIV   = 7'b0000001;

  typedef enum logic [2:0] {
    F3_MUL    = 3'b000,
    F3_MULH   = 3'b001,
    F3_MULHSU = 3'b010,
    F3_MULHU  = 3'b011
  } mul_f3_e;

  typedef struct packed {
    logic                 illegal;
    logic                 a_signed;
    logic                 b_signed;
    logic                 take_hi;
    logic [REG_IDX_W-1:0] rd;
  } mul_ctl_t;
endpackage

// File: rtl/mulh_decode.sv
module mulh_decode
  import mulh_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output mul_ctl_t        ctl_o
);
  logic [6:0] opcode;
  logic [6:0] funct7;
  logic [2:0] funct3;
  logic       group_hit;
  logic       unused_src_idx;

  assign opcode         = instr_i[6:0];
  assign funct7         = instr_i[31:25];
  assign funct3         = instr_i[14:12];
  assign group_hit      = (opcode == OPC_REG_REG) && (funct7 == F7_MULDIV);
  assign unused_src_idx = ^instr_i[24:15];

  always_comb begin
    ctl_o          = '0;
    ctl_o.rd       = instr_i[11:7];
    ctl_o.illegal  = 1'b1;
    if (group_hit) begin
      unique case (funct3)
        F3_MUL:    begin ctl_o.illegal = 1'b0; end
        F3_MULH:   begin ctl_o.illegal = 1'b0; ctl_o.take_hi = 1'b1;
                         ctl_o.a_signed = 1'b1; ctl_o.b_signed = 1'b1; end
        F3_MULHSU: begin ctl_o.illegal = 1'b0; ctl_o.take_hi = 1'b1;
                         ctl_o.a_signed = 1'b1; end
        F3_MULHU:  begin ctl_o.illegal = 1'b0; ctl_o.take_hi = 1'b1; end
        default:   ctl_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mulh_core.sv
module mulh_core
  import mulh_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  mul_ctl_t      ctl_i,
  input  logic          pop_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2*W-1:0] prod_o,
  output mul_ctl_t      ctl_o
);
  localparam int unsigned PW = 2 * W;

  logic [W:0]    a_ext, b_ext;
  logic [PW-1:0] prod_in;
  logic [LAT-1:0] v_vec;

  // extend by one bit so every operand kind fits a signed multiply
  assign a_ext   = {ctl_i.a_signed & a_i[W-1], a_i};
  assign b_ext   = {ctl_i.b_signed & b_i[W-1], b_i};
  assign prod_in = PW'($signed(a_ext)) * PW'($signed(b_ext));

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    logic          ld;
    logic          v_next;
    logic          v_q;
    logic [PW-1:0] p_in, p_q;
    mul_ctl_t      c_in, c_q;

    if (i == 0) begin : g_head
      assign ld   = start_i;
      assign p_in = prod_in;
      assign c_in = ctl_i;
    end else begin : g_body
      assign ld   = g_stage[i-1].v_q;
      assign p_in = g_stage[i-1].p_q;
      assign c_in = g_stage[i-1].c_q;
    end

    if (i == LAT - 1) begin : g_tail
      assign v_next = ld | (v_q & ~pop_i);
    end else begin : g_pass
      assign v_next = ld;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) v_q <= 1'b0;
      else         v_q <= v_next;
    end

    always_ff @(posedge clk_i) begin
      if (ld) begin
        p_q <= p_in;
        c_q <= c_in;
      end
    end

    assign v_vec[i] = v_q;
  end

  assign busy_o = |v_vec;
  assign done_o = g_stage[LAT-1].v_q;
  assign prod_o = g_stage[LAT-1].p_q;
  assign ctl_o  = g_stage[LAT-1].c_q;
endmodule

// File: rtl/mulh_select.sv
module mulh_select
  import mulh_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [2*W-1:0] prod_i,
  input  mul_ctl_t       ctl_i,
  output logic [W-1:0]   data_o
);
  always_comb begin
    if (ctl_i.illegal)      data_o = '0;
    else if (ctl_i.take_hi) data_o = prod_i[2*W-1:W];
    else                    data_o = prod_i[W-1:0];
  end
endmodule

// File: rtl/mulh_unit.sv
module mulh_unit
  import mulh_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] out_data_o,
  output logic [REG_IDX_W-1:0] out_rd_o,
  output logic            out_illegal_o
);
  mul_ctl_t          dec_ctl, res_ctl;
  logic              start, pop, busy, done;
  logic [2*XLEN-1:0] prod;

  assign in_ready_o = ~busy;
  assign start      = in_valid_i & in_ready_o;
  assign pop        = done & out_ready_i;

  mulh_decode i_decode (
    .instr_i (instr_i),
    .ctl_o   (dec_ctl)
  );

  mulh_core #(.W(XLEN), .LAT(LAT)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .a_i     (rs1_val_i),
    .b_i     (rs2_val_i),
    .ctl_i   (dec_ctl),
    .pop_i   (pop),
    .busy_o  (busy),
    .done_o  (done),
    .prod_o  (prod),
    .ctl_o   (res_ctl)
  );

  mulh_select #(.W(XLEN)) i_select (
    .prod_i (prod),
    .ctl_i  (res_ctl),
    .data_o (out_data_o)
  );

  assign out_valid_o   = done;
  assign out_rd_o      = res_ctl.rd;
  assign out_illegal_o = res_ctl.illegal;
endmodule

// File: rtl/mulh_unit_chk.sv
module mulh_unit_chk #(
  parameter int unsigned LAT = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic [4:0]  out_rd_o,
  input logic        out_illegal_o
);
  logic [15:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (in_valid_i && in_ready_o)    cnt_q <= 16'd1;
    else if (cnt_q != 0 && !out_valid_o)  cnt_q <= cnt_q + 16'd1;
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> cnt_q == 16'(LAT));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_rd_o) && $stable(out_illegal_o)));

  a_r9_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (!out_valid_o && in_ready_o));

  a_r6_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_illegal_o) |-> out_data_o == 32'd0);
endmodule

bind mulh_unit mulh_unit_chk #(.LAT(LAT)) i_mulh_unit_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_data_o    (out_data_o),
  .out_rd_o      (out_rd_o),
  .out_illegal_o (out_illegal_o)
);

// File: tb/test_mulh_unit.sv
module test_mulh_unit;
  localparam int unsigned LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0, rs1 = '0, rs2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [4:0]  out_rd;
  logic        out_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mulh_unit #(.LAT(LAT)) i_mulh_unit (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_ready_o (in_ready),
    .instr_i (instr), .rs1_val_i (rs1), .rs2_val_i (rs2),
    .out_valid_o (out_valid), .out_ready_i (out_ready),
    .out_data_o (out_data), .out_rd_o (out_rd), .out_illegal_o (out_illegal)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, 5'd7, 5'd3, f3, rd, opc};
  endfunction

  // reference: 64-bit wrap-around product of the extended operands
  function automatic void ref_op(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] res, output logic ill);
    logic [63:0] ea, eb, p;
    ill = !(iw[6:0] == 7'h33 && iw[31:25] == 7'h01 && iw[14] == 1'b0);
    ea = {32'd0, a};
    eb = {32'd0, b};
    if (iw[14:12] == 3'b001 || iw[14:12] == 3'b010) ea = {{32{a[31]}}, a};
    if (iw[14:12] == 3'b001) eb = {{32{b[31]}}, b};
    p = ea * eb;
    if (ill) res = 32'd0;
    else if (iw[14:12] == 3'b000) res = p[31:0];
    else res = p[63:32];
  endfunction

  task automatic run_op(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                        input int stall, input string req, input bit use_lit, input logic [31:0] lit);
    logic [31:0] e_data;
    logic        e_ill;
    int          lat;
    ref_op(iw, a, b, e_data, e_ill);
    if (use_lit) e_data = lit;
    @(negedge clk);
    instr = iw; rs1 = a; rs2 = b; in_valid = 1'b1;
    check(in_ready == 1'b1, "R9 ready before issue", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    instr = $urandom; rs1 = $urandom; rs2 = $urandom;
    check(in_ready == 1'b0, "R9 busy after accept", 64'(in_ready), 64'd0);
    lat = 1;
    while (!out_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check(lat == LAT, "R7 latency", 64'(lat), 64'(LAT));
    check(out_data == e_data, req, 64'(out_data), 64'(e_data));
    check(out_illegal == e_ill, "R6 illegal flag", 64'(out_illegal), 64'(e_ill));
    check(out_rd == iw[11:7], "R5 rd", 64'(out_rd), 64'(iw[11:7]));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(out_valid && out_data == e_data && out_rd == iw[11:7] && !in_ready,
            "R8 hold under stall", 64'(out_data), 64'(e_data));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R9 release after take", 64'({out_valid, in_ready}), 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] specials [5];
    process::self().srandom(32'd1234);
    specials = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R10 reset state", 64'({out_valid, in_ready}), 64'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R10 after reset", 64'({out_valid, in_ready}), 64'b01);

    // directed corners with literal expectations
    run_op(mk(7'h01, 3'b000, 5'd1, 7'h33), 32'h80000000, 32'hFFFFFFFF, 0, "R1 MUL corner", 1, 32'h80000000);
    run_op(mk(7'h01, 3'b001, 5'd2, 7'h33), 32'h80000000, 32'hFFFFFFFF, 1, "R2 MULH corner", 1, 32'h00000000);
    run_op(mk(7'h01, 3'b011, 5'd3, 7'h33), 32'h80000000, 32'hFFFFFFFF, 2, "R3 MULHU corner", 1, 32'h7FFFFFFF);
    run_op(mk(7'h01, 3'b010, 5'd4, 7'h33), 32'h80000000, 32'hFFFFFFFF, 0, "R4 MULHSU corner", 1, 32'h80000000);
    run_op(mk(7'h01, 3'b010, 5'd5, 7'h33), 32'hFFFFFFFF, 32'hFFFFFFFF, 1, "R4 MULHSU negative rs1", 1, 32'hFFFFFFFF);
    run_op(mk(7'h01, 3'b010, 5'd6, 7'h33), 32'hFFFFFFFF, 32'h80000000, 0, "R4 MULHSU no swap", 1, 32'hFFFFFFFF);
    run_op(mk(7'h01, 3'b010, 5'd7, 7'h33), 32'h00000002, 32'hFFFFFFFF, 0, "R4 MULHSU positive rs1", 1, 32'h00000001);
    run_op(mk(7'h01, 3'b100, 5'd8, 7'h33), 32'h12345678, 32'h9, 2, "R6 funct3 out of group", 0, 32'h0);
    run_op(mk(7'h00, 3'b000, 5'd9, 7'h33), 32'h12345678, 32'h9, 0, "R6 other funct7", 0, 32'h0);
    run_op(mk(7'h01, 3'b001, 5'd10, 7'h13), 32'h12345678, 32'h9, 0, "R6 other opcode", 0, 32'h0);

    for (int i = 0; i < 300; i++) begin
      logic [2:0]  f3;
      logic [6:0]  f7, opc;
      logic [31:0] a, b;
      f3  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
      f7  = ($urandom_range(0, 19) == 0) ? 7'h20 : 7'h01;
      opc = ($urandom_range(0, 19) == 0) ? 7'h03 : 7'h33;
      a   = ($urandom_range(0, 3) == 0) ? specials[$urandom_range(0, 4)] : $urandom;
      b   = ($urandom_range(0, 3) == 0) ? specials[$urandom_range(0, 4)] : $urandom;
      run_op(mk(f7, f3, 5'($urandom), opc), a, b, $urandom_range(0, 3),
             "R1 R2 R3 R4 random result", 0, 32'h0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule